// File: doc/BRIEF.md
# Pulse-Width Qualified Carrier and Collision Detector

This block turns a sampled, already-thresholded line-activity indication into a clean receive-enable for a serial receiver. Activity is reported one bit per clock, high while the differential input sits below the carrier threshold. A single short excursion is treated as noise. A run of activity must reach a minimum length before receive-enable asserts. Once receive is enabled, it stays up until the line has been quiet for a fixed number of samples after its last return from the active level. After that, it drops on the next rising edge of the recovered receive clock. A hold-off timer then keeps receive-enable low for a fixed window so that line ringing cannot restart it. The rising edge of receive-enable also emits a single-cycle start pulse that launches the decoder's clock acquisition.

A second, independent path does the same qualification for the collision-pair activity. A collision flag asserts after a short minimum run and falls once the collision input has stayed inactive for a fixed number of samples. All thresholds are counts of sample periods and are set by parameters. With a 12.5 ns sample period, the defaults give the following windows: turn-on at 50 ns, quiet timeout at 162.5 ns, hold-off at 125 ns, collision turn-on at 37.5 ns and collision timeout at 162.5 ns.

Top module: `cdet_top`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `rx_en`, `acq_start` and `col_flag` are all 0.
- R2: `rx_en` rises at the clock edge that samples the 4th consecutive high value of `rx_neg` (ON_SAMPLES), provided the hold-off window is clear. A run of 1, 2 or 3 high samples followed by a low sample leaves `rx_en` at 0.
- R3: `acq_start` is 1 for exactly the one cycle that follows each rising edge of `rx_en`, and is 0 at all other times.
- R4: While receive is enabled, the carrier is judged gone at the edge that samples the 13th consecutive low value of `rx_neg` (OFF_SAMPLES). Any high sample restarts this count from zero.
- R5: After the carrier is judged gone, `rx_en` falls at the first edge, counting the edge at which it is judged gone, where `rclk_rise` is sampled at 1. Until that edge, `rx_en` stays at 1.
- R6: After `rx_en` falls, it cannot rise at any of the next 10 edges (HOLD_SAMPLES). Activity that is still present then qualifies at the 11th edge, if its run is already long enough by then.
- R7: `col_flag` rises at the edge that samples the 3rd consecutive high value of `col_neg` (COL_ON_SAMPLES). Runs of 1 or 2 high samples leave it at 0.
- R8: `col_flag` falls at the edge that samples the 13th consecutive low value of `col_neg` (COL_OFF_SAMPLES). A high sample before that keeps it at 1 and restarts the count.
- R9: `col_neg` has no effect on `rx_en` or `acq_start`, and `rx_neg` and `rclk_rise` have no effect on `col_flag`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_neg | input | 1 | Receive pair below carrier threshold (1 = active) |
| col_neg | input | 1 | Collision pair below threshold (1 = active) |
| rclk_rise | input | 1 | One-cycle strobe marking a recovered-clock rising edge |
| rx_en | output | 1 | Qualified receive enable (registered) |
| acq_start | output | 1 | One-cycle start pulse for clock acquisition |
| col_flag | output | 1 | Qualified collision indication (registered) |

## Verification
The bench targets the boundaries of each window. It drives runs one sample shorter than the turn-on length and runs of exactly that length; a detector that is off by one either passes a three-sample glitch or needs a fifth sample. It restarts the quiet count with a single active sample, so a timer that counts from the first quiet sample instead of the last would drop receive early. It withholds the clock strobe past the timeout, so an unaligned drop would show up immediately. It holds the line active across the hold-off window, so a window that is one edge short or one edge long moves the re-assertion edge. Collision and receive stimuli are also interleaved at random, so any coupling between the two paths would change an output that a cycle-accurate model predicts.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_LIVE  = 2'd1,
    RX_DRAIN = 2'd2
  } rx_state_e;
endpackage

// File: rtl/cdet_runlen.sv
// Counts consecutive high samples of din, saturating at N-1.
// hit is high when the current sample completes a run of at least N.
module cdet_runlen #(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic hit
);
  localparam int CW = (N > 1) ? $clog2(N) : 1;
  localparam logic [CW-1:0] SAT = CW'(N - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (!din)
      cnt <= '0;
    else if (cnt != SAT)
      cnt <= cnt + 1'b1;
  end

  assign hit = din && (cnt == SAT);
endmodule

// File: rtl/cdet_holdoff.sv
// Re-assertion blocking timer: busy for HOLD edges after load.
module cdet_holdoff #(
  parameter int HOLD = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic busy
);
  localparam int HW = $clog2(HOLD + 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLD);

  logic [HW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= HMAX;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R6: a load always opens a blocking window on the next cycle
  assert_busy_after_load_R6: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
endmodule

// File: rtl/cdet_rx_fsm.sv
// Receive-enable sequencing: idle -> live -> drain (wait for clock) -> idle.
module cdet_rx_fsm
  import cdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic qual_on,
  input  logic quiet_hit,
  input  logic rclk_rise,
  input  logic hold_busy,
  output logic hold_load,
  output logic rx_en,
  output logic acq_start
);
  rx_state_e state, state_n;
  logic      start_now;
  logic      gone_now;

  always_comb begin
    start_now = (state == RX_IDLE) && qual_on && !hold_busy;
    gone_now  = (state == RX_LIVE) && quiet_hit;
    hold_load = ((state == RX_DRAIN) || gone_now) && rclk_rise;
    state_n   = state;
    if (start_now)      state_n = RX_LIVE;
    else if (hold_load) state_n = RX_IDLE;
    else if (gone_now)  state_n = RX_DRAIN;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      rx_en     <= 1'b0;
      acq_start <= 1'b0;
    end else begin
      state     <= state_n;
      rx_en     <= (state_n != RX_IDLE);
      acq_start <= start_now;
    end
  end

  // R3: the start pulse only accompanies a fresh rise of rx_en
  assert_acq_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
    acq_start |-> (rx_en && !$past(rx_en)));
  // R5: receive enable only drops on a sampled recovered-clock edge
  assert_fall_on_rclk_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(rx_en) |-> $past(rclk_rise));
  // R6: no re-assertion while the hold-off window is open
  assert_no_rise_in_holdoff_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_en) |-> !$past(hold_busy));
  // R2: a rise needs a qualified run on the sampled edge
  assert_rise_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_en) |-> $past(qual_on));
endmodule

// File: rtl/cdet_col_flag.sv
// Collision indication: qualified turn-on, quiet-run turn-off.
module cdet_col_flag #(
  parameter int ON_N  = 3,
  parameter int OFF_N = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic flag
);
  logic on_hit;
  logic off_hit;

  cdet_runlen #(.N(ON_N)) u_on (
    .clk(clk), .rst(rst), .din(din), .hit(on_hit)
  );

  cdet_runlen #(.N(OFF_N)) u_off (
    .clk(clk), .rst(rst), .din(!din), .hit(off_hit)
  );

  always_ff @(posedge clk) begin
    if (rst)
      flag <= 1'b0;
    else if (!flag && on_hit)
      flag <= 1'b1;
    else if (flag && off_hit)
      flag <= 1'b0;
  end

  // R7: the flag rises only on a sampled active level
  assert_col_rise_active_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(din));
  // R8: the flag falls only on a sampled quiet level
  assert_col_fall_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(flag) |-> !$past(din));
endmodule

// File: rtl/cdet_top.sv
module cdet_top #(
  parameter int ON_SAMPLES      = 4,
  parameter int OFF_SAMPLES     = 13,
  parameter int HOLD_SAMPLES    = 10,
  parameter int COL_ON_SAMPLES  = 3,
  parameter int COL_OFF_SAMPLES = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_neg,
  input  logic col_neg,
  input  logic rclk_rise,
  output logic rx_en,
  output logic acq_start,
  output logic col_flag
);
  logic qual_on;
  logic quiet_hit;
  logic hold_busy;
  logic hold_load;

  cdet_runlen #(.N(ON_SAMPLES)) u_on_run (
    .clk(clk), .rst(rst), .din(rx_neg), .hit(qual_on)
  );

  cdet_runlen #(.N(OFF_SAMPLES)) u_quiet_run (
    .clk(clk), .rst(rst), .din(!rx_neg), .hit(quiet_hit)
  );

  cdet_holdoff #(.HOLD(HOLD_SAMPLES)) u_hold (
    .clk(clk), .rst(rst), .load(hold_load), .busy(hold_busy)
  );

  cdet_rx_fsm u_fsm (
    .clk(clk), .rst(rst), .qual_on(qual_on), .quiet_hit(quiet_hit),
    .rclk_rise(rclk_rise), .hold_busy(hold_busy), .hold_load(hold_load),
    .rx_en(rx_en), .acq_start(acq_start)
  );

  cdet_col_flag #(.ON_N(COL_ON_SAMPLES), .OFF_N(COL_OFF_SAMPLES)) u_col (
    .clk(clk), .rst(rst), .din(col_neg), .flag(col_flag)
  );

  // R1: outputs are clear in the cycle after reset
  assert_reset_clear_R1: assert property (@(posedge clk)
    $past(rst) |-> (!rx_en && !acq_start && !col_flag));
endmodule

// File: tb/cdet_top_test.sv
`timescale 1ns/1ps
module cdet_top_test;
  localparam int ON   = 4;
  localparam int OFF  = 13;
  localparam int HOLD = 10;
  localparam int CON  = 3;
  localparam int COFF = 13;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_neg = 1'b0;
  logic col_neg = 1'b0;
  logic rclk_rise = 1'b0;
  logic rx_en, acq_start, col_flag;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  cdet_top uut (
    .clk(clk), .rst(rst), .rx_neg(rx_neg), .col_neg(col_neg),
    .rclk_rise(rclk_rise), .rx_en(rx_en), .acq_start(acq_start),
    .col_flag(col_flag)
  );

  // Behavioural reference: state 0 idle, 1 live, 2 waiting for clock
  int m_state = 0, m_run = 0, m_quiet = 0, m_hold = 0;
  int m_crun = 0, m_cquiet = 0;
  bit m_en = 0, m_acq = 0, m_col = 0;

  always @(posedge clk) begin
    bit start_ok, gone, drop;
    if (rst) begin
      m_state = 0; m_run = 0; m_quiet = 0; m_hold = 0;
      m_crun = 0; m_cquiet = 0; m_en = 0; m_acq = 0; m_col = 0;
    end else begin
      start_ok = (m_state == 0) && rx_neg && (m_run >= ON - 1) && (m_hold == 0);
      gone     = (m_state == 1) && !rx_neg && (m_quiet >= OFF - 1);
      drop     = ((m_state == 2) || gone) && rclk_rise;
      m_acq    = start_ok;
      if (drop) m_hold = HOLD;
      else if (m_hold > 0) m_hold = m_hold - 1;
      if (start_ok) begin m_state = 1; m_en = 1; end
      else if (drop) begin m_state = 0; m_en = 0; end
      else if (gone) m_state = 2;
      m_run   = rx_neg ? m_run + 1 : 0;
      m_quiet = rx_neg ? 0 : m_quiet + 1;
      if (!m_col && col_neg && m_crun >= CON - 1) m_col = 1;
      else if (m_col && !col_neg && m_cquiet >= COFF - 1) m_col = 0;
      m_crun   = col_neg ? m_crun + 1 : 0;
      m_cquiet = col_neg ? 0 : m_cquiet + 1;
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      check("R2/R4/R5/R6 rx_en model", rx_en, m_en);
      check("R3 acq_start model", acq_start, m_acq);
      check("R7/R8 col_flag model", col_flag, m_col);
    end
  end

  task automatic drive(input logic rn, input logic cn, input logic rr, input int n);
    for (int i = 0; i < n; i++) begin
      rx_neg = rn; col_neg = cn; rclk_rise = rr;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rx_en reset", rx_en, 1'b0);
    check("R1 acq_start reset", acq_start, 1'b0);
    check("R1 col_flag reset", col_flag, 1'b0);
    rst = 1'b0;
    drive(0, 0, 0, 1);
    check("R1 rx_en after release", rx_en, 1'b0);

    // R2: short runs rejected
    drive(1, 0, 0, 1); drive(0, 0, 0, 2);
    check("R2 one-sample run", rx_en, 1'b0);
    drive(1, 0, 0, 3); drive(0, 0, 0, 1);
    check("R2 three-sample run", rx_en, 1'b0);
    drive(1, 0, 0, 3);
    check("R2 not yet at third", rx_en, 1'b0);
    drive(1, 0, 1, 1);
    check("R2 rise at fourth", rx_en, 1'b1);
    check("R3 start pulse", acq_start, 1'b1);
    check("R9 col_flag unaffected", col_flag, 1'b0);
    drive(0, 0, 1, 1);
    check("R3 pulse one cycle", acq_start, 1'b0);

    // R4: quiet count restarts on any active sample
    drive(0, 0, 1, 11);
    check("R4 twelve quiet", rx_en, 1'b1);
    drive(1, 0, 1, 1);
    drive(0, 0, 1, 12);
    check("R4 restarted count", rx_en, 1'b1);
    drive(0, 0, 1, 1);
    check("R4 drop at thirteenth", rx_en, 1'b0);

    // R6: hold-off with line held active
    drive(1, 0, 0, 10);
    check("R6 blocked in window", rx_en, 1'b0);
    drive(1, 0, 0, 1);
    check("R6 rise after window", rx_en, 1'b1);
    check("R3 pulse after hold-off", acq_start, 1'b1);

    // R5: drop waits for the clock strobe
    drive(0, 0, 0, 15);
    check("R5 held without strobe", rx_en, 1'b1);
    drive(0, 0, 1, 1);
    check("R5 drop on strobe", rx_en, 1'b0);
    drive(0, 0, 0, 20);

    // R7/R8/R9: collision path
    drive(0, 1, 0, 2); drive(0, 0, 0, 2);
    check("R7 two-sample run", col_flag, 1'b0);
    drive(0, 1, 0, 3);
    check("R7 rise at third", col_flag, 1'b1);
    check("R9 rx_en unaffected", rx_en, 1'b0);
    check("R9 acq unaffected", acq_start, 1'b0);
    drive(0, 0, 0, 12);
    check("R8 twelve quiet", col_flag, 1'b1);
    drive(0, 0, 0, 1);
    check("R8 drop at thirteenth", col_flag, 1'b0);

    // Mixed random traffic, compared to the model every cycle
    for (int c = 0; c < 4000; c++) begin
      logic rn, cn, rr;
      rn = ($urandom_range(0, 3) == 0) ? ~rx_neg : rx_neg;
      cn = ($urandom_range(0, 4) == 0) ? ~col_neg : col_neg;
      rr = ($urandom_range(0, 3) == 0);
      drive(rn, cn, rr, 1);
    end
    drive(0, 0, 1, 40);
    check("R9 idle after traffic", rx_en, 1'b0);
    finish_run();
  end
endmodule